// File: doc/BRIEF.md
# Triggered Lookback Pulse Extractor

This block watches one channel of 12-bit digitized detector samples. Every sample clock it stores the incoming sample in a 1024-entry circular memory and never stops doing so. The memory therefore always holds the most recent stretch of signal history, long enough to cover the delay of a first-level trigger decision. No analog delay line is needed in front of the converter.

When a trigger strobe is accepted, the block reaches back a programmable number of samples into that history and walks forward through a window of programmable length. While it walks, it accumulates the integral of the samples. It also locates the leading edge of any pulse, which is the first sample at or above a programmable threshold. That edge time is refined to 1/16 of a sample by linear interpolation against the preceding sample. At the end of the window the block presents one result record, qualified by a single-cycle valid.

A trigger that arrives while an extraction is still running is not served. Such triggers are tallied in a counter.

Top module: `pulse_extract`

## Requirements
- R1: The sample on `smp_in` is stored every clock after reset, and the write pointer advances by one every clock, whether or not a trigger is present or an extraction is running.
- R2: For a trigger accepted at clock edge E, with effective lookback L and window W, the window holds the W consecutive samples that were presented at edges E-L through E-L+W-1.
- R3: The effective window is `cfg_win`, or 1 when `cfg_win` is 0. The effective lookback is `cfg_lat` raised to the effective window when smaller, then limited to 1023.
- R4: `res_sum` is the exact unsigned sum of the window samples. It is 22 bits wide, so 1023 samples of 4095 give 4189185 without overflow.
- R5: With threshold H, let k be the first window index whose sample v is at least H. `res_time` is 0 when k is 0. Otherwise it is 16*(k-1) + floor(16*(H-p)/(v-p)), where p is the sample at index k-1. The field is 14 bits wide, in units of 1/16 sample.
- R6: When no window sample reaches the threshold, `res_nohit` is 1, `res_time` is 16383 (all ones) and `res_sum` is still reported. Otherwise `res_nohit` is 0.
- R7: `res_valid` is high for exactly one clock: the clock that follows edge E+W+1 for a trigger accepted at edge E. The threshold and the window length are captured at edge E.
- R8: A trigger sampled at any edge from E+1 through E+W+1 is ignored, and each such trigger increments `drop_cnt` by one. It changes neither the pending result nor its timing. A trigger at edge E+W+2 or later is accepted.
- R9: Reset clears `res_valid`, `res_nohit`, `res_sum`, `res_time` and `drop_cnt` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_in | input | 12 | ADC sample, one per clock |
| trig | input | 1 | Trigger strobe, sampled each edge |
| cfg_lat | input | 11 | Lookback distance in samples |
| cfg_win | input | 10 | Integration window length in samples |
| cfg_thr | input | 12 | Leading-edge threshold |
| res_valid | output | 1 | Result record valid, one clock |
| res_sum | output | 22 | Window integral |
| res_time | output | 14 | Leading-edge time, 4 fractional bits |
| res_nohit | output | 1 | No sample reached the threshold |
| drop_cnt | output | 16 | Count of triggers ignored while busy |

## Verification
Full-range random samples exercise the integral and the first-crossing search on noisy data. A low baseline carrying triangular pulses of random height exercises the interpolated edge time, including misses on small pulses, and so separates a wrong crossing index from a wrong fraction. A constant full-scale input over the widest window exposes integral overflow and the index-zero hit. Out-of-range lookback and window settings check the clamping. Triggers placed one edge before and exactly at the end of the busy span check the drop boundary, and show that a threshold change during an extraction has no effect on the pending result.

// File: rtl/pulse_extract.sv
module pulse_extract #(
  parameter int SW = 12,
  parameter int AW = 10,
  parameter int IW = 22,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] smp_in,
  input  logic          trig,
  input  logic [AW:0]   cfg_lat,
  input  logic [AW-1:0] cfg_win,
  input  logic [SW-1:0] cfg_thr,
  output logic          res_valid,
  output logic [IW-1:0] res_sum,
  output logic [AW+3:0] res_time,
  output logic          res_nohit,
  output logic [DW-1:0] drop_cnt
);
  localparam int DEPTH = 1 << AW;
  localparam int TW = AW + 4;

  logic [SW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr, left, k;
  logic [SW-1:0] rdata, prev, thr_q;
  logic [IW-1:0] acc;
  logic [TW-1:0] tim;
  logic          busy, rv, rl, hit;

  logic [AW-1:0] win_e;
  logic [AW:0]   lat_lo, lat_e;
  assign win_e  = (cfg_win == '0) ? AW'(1) : cfg_win;
  assign lat_lo = (cfg_lat < {1'b0, win_e}) ? {1'b0, win_e} : cfg_lat;
  assign lat_e  = (lat_lo > (AW+1)'(DEPTH-1)) ? (AW+1)'(DEPTH-1) : lat_lo;

  logic          cx;
  logic [SW+3:0] num, den, frac;
  logic [AW-1:0] km1;
  logic [TW-1:0] tnew;
  assign cx   = rv && !hit && (rdata >= thr_q);
  assign num  = {thr_q - prev, 4'b0};
  assign den  = (rdata == prev) ? (SW+4)'(1) : (SW+4)'(rdata - prev);
  assign frac = num / den;
  assign km1  = k - AW'(1);
  assign tnew = (k == '0) ? '0 : ({km1, 4'b0} + TW'(frac[4:0]));

  always_ff @(posedge clk) begin
    mem[wptr] <= smp_in;
    rdata     <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; left <= '0; k <= '0;
      prev <= '0; thr_q <= '0; acc <= '0; tim <= '0;
      busy <= 1'b0; rv <= 1'b0; rl <= 1'b0; hit <= 1'b0;
      res_valid <= 1'b0; res_sum <= '0; res_time <= '0;
      res_nohit <= 1'b0; drop_cnt <= '0;
    end else begin
      wptr      <= wptr + AW'(1);
      rv        <= 1'b0;
      rl        <= 1'b0;
      res_valid <= 1'b0;
      if (trig && busy) drop_cnt <= drop_cnt + DW'(1);
      if (trig && !busy) begin
        busy  <= 1'b1;
        rptr  <= wptr - lat_e[AW-1:0];
        left  <= win_e;
        thr_q <= cfg_thr;
        acc   <= '0;
        hit   <= 1'b0;
        k     <= '0;
        prev  <= '0;
      end else if (busy && left != '0) begin
        rv   <= 1'b1;
        rl   <= (left == AW'(1));
        rptr <= rptr + AW'(1);
        left <= left - AW'(1);
      end
      if (rv) begin
        acc  <= acc + IW'(rdata);
        prev <= rdata;
        k    <= k + AW'(1);
        if (cx) begin
          hit <= 1'b1;
          tim <= tnew;
        end
        if (rl) begin
          busy      <= 1'b0;
          res_valid <= 1'b1;
          res_sum   <= acc + IW'(rdata);
          res_nohit <= !(hit || cx);
          res_time  <= hit ? tim : (cx ? tnew : '1);
        end
      end
    end
  end
endmodule

module pulse_extract_chk #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trig,
  input logic          busy,
  input logic [AW-1:0] wptr,
  input logic          res_valid,
  input logic          res_nohit,
  input logic [AW+3:0] res_time,
  input logic [DW-1:0] drop_cnt
);
  // R1
  wptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> wptr == $past(wptr) + AW'(1));
  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  // R6
  nohit_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_nohit) |-> (&res_time));
  // R8
  drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (drop_cnt == $past(drop_cnt) || drop_cnt == $past(drop_cnt) + DW'(1)));
  // R8
  accept_nodrop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !busy) |=> drop_cnt == $past(drop_cnt));
endmodule

bind pulse_extract pulse_extract_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .busy(busy), .wptr(wptr),
  .res_valid(res_valid), .res_nohit(res_nohit), .res_time(res_time),
  .drop_cnt(drop_cnt)
);

// File: tb/test_pulse_extract.sv
module test_pulse_extract;
  localparam int CLK_P = 4;
  localparam int HMAX = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] smp_in = '0;
  logic        trig = 1'b0;
  logic [10:0] cfg_lat = '0;
  logic [9:0]  cfg_win = '0;
  logic [11:0] cfg_thr = '0;
  logic        res_valid, res_nohit;
  logic [21:0] res_sum;
  logic [13:0] res_time;
  logic [15:0] drop_cnt;

  pulse_extract i_pulse_extract (.*);

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errs = 0, cyc = 0, mode = 0, amp = 0;
  logic [11:0] hist [HMAX];

  typedef struct { int cyc; int sum; int tim; int nohit; } exp_t;
  exp_t exp_q [$];

  always @(posedge clk) begin
    hist[cyc] <= smp_in;
    cyc <= cyc + 1;
  end

  function automatic logic [11:0] gen();
    int ph, v;
    case (mode)
      0: return 12'($urandom_range(0, 4095));
      2: return 12'd4095;
      default: begin
        ph = cyc % 50;
        if (ph == 0) amp = $urandom_range(0, 300);
        v = 100 + $urandom_range(0, 8);
        if (ph < 10) v += ph * amp;
        else if (ph < 20) v += (20 - ph) * amp;
        return 12'(v);
      end
    endcase
  endfunction

  always @(negedge clk) smp_in <= gen();

  task automatic chk(input string tag, input longint got, input longint ex);
    checks++;
    if (got != ex) begin
      errs++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, ex);
    end
  endtask

  // R2 window placement, R3 clamping, R4 integral, R5/R6 edge time
  function automatic exp_t model(int e, int lat, int win, int thr);
    exp_t r;
    int we, le, s, v, p;
    bit hit = 0;
    we = (win == 0) ? 1 : win;
    le = (lat < we) ? we : lat;
    if (le > 1023) le = 1023;
    s = e - le;
    r.sum = 0; r.tim = 16383; r.nohit = 1;
    r.cyc = e + we + 2;
    for (int k = 0; k < we; k++) begin
      v = hist[s + k];
      r.sum += v;
      if (!hit && v >= thr) begin
        hit = 1; r.nohit = 0;
        if (k == 0) r.tim = 0;
        else begin
          p = hist[s + k - 1];
          r.tim = 16 * (k - 1) + (16 * (thr - p)) / (v - p);
        end
      end
    end
    return r;
  endfunction

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) chk("R7 unexpected valid", 1, 0);
      else begin
        exp_t x;
        x = exp_q.pop_front();
        chk("R7 result cycle", cyc, x.cyc);
        chk("R4 integral", res_sum, x.sum);
        chk("R5 time", res_time, x.tim);
        chk("R6 nohit", res_nohit, x.nohit);
      end
    end
  end

  task automatic fire(input int e, input int lat, input int win, input int thr, input bit acc);
    while (cyc < e) @(negedge clk);
    cfg_lat = 11'(lat); cfg_win = 10'(win); cfg_thr = 12'(thr);
    trig = 1'b1;
    if (acc) exp_q.push_back(model(cyc, lat, win, thr));
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 3000) begin @(negedge clk); n++; end
    chk("R7 pending results", exp_q.size(), 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * HMAX);
    chk("watchdog", 1, 0);
    finish_run();
  end

  initial begin
    int base, e0;
    mode = 1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    chk("R9 res_valid", res_valid, 0);
    chk("R9 drop_cnt", drop_cnt, 0);
    chk("R9 res_sum", res_sum, 0);
    chk("R9 res_time", res_time, 0);
    chk("R9 res_nohit", res_nohit, 0);
    repeat (1100) @(negedge clk);
    fire(cyc, 300, 64, 1000, 1); drain();      // R2, R5 pulse window
    fire(cyc, 600, 120, 4095, 1); drain();     // R6 nothing crosses
    fire(cyc, 400, 80, 0, 1); drain();         // R5 index zero
    fire(cyc, 0, 0, 500, 1); drain();          // R3 both clamped to 1
    fire(cyc, 2047, 20, 600, 1); drain();      // R3 lookback limit
    fire(cyc, 5, 40, 700, 1); drain();         // R3 lookback raised
    mode = 2;
    repeat (1100) @(negedge clk);
    fire(cyc, 1023, 1023, 4095, 1); drain();   // R4 full scale
    mode = 1;
    repeat (1100) @(negedge clk);
    // R8 drop boundary and threshold latching
    base = drop_cnt;
    e0 = cyc + 2;
    fire(e0, 200, 50, 1000, 1);
    fire(e0 + 3, 200, 50, 0, 0);
    fire(e0 + 51, 200, 50, 0, 0);
    fire(e0 + 52, 200, 50, 1000, 1);
    drain();
    chk("R8 dropped count", drop_cnt, base + 2);
    // R1 continuous writing across random extractions
    base = drop_cnt;
    for (int i = 0; i < 40; i++) begin
      mode = (i % 3 == 0) ? 0 : 1;
      repeat ($urandom_range(1, 20)) @(negedge clk);
      fire(cyc, $urandom_range(0, 2047), $urandom_range(0, 1023),
           $urandom_range(0, 1500), 1);
      drain();
    end
    chk("R8 no drops when idle", drop_cnt, base);
    finish_run();
  end

  initial begin
    process p;
    p = process::self();
    p.srandom(12345);
  end
endmodule